// File: doc/BRIEF.md
# Serially Loaded Display Register Bank

This block keeps four byte-wide display values that a distant controller updates over a four-wire link: one serial data bit, a two-bit register address and a shift strobe. On every clock edge where the strobe is high, a decoder enables only the addressed register. That register shifts right by one place and takes the serial bit into its top position. Registers that are not addressed keep their contents. The same happens to every register when the strobe is low.

A separate two-bit view select drives a four-way selector. The selector presents one register's full byte on the display output in the same cycle. A bit tracker counts strobed bits sent to the same address. When the eighth such bit lands, it raises a one-cycle frame-complete pulse, so the receiving side knows that a whole byte has arrived. Register count and width are parameters. The defaults give four registers of eight bits.

Top module: `serial_disp_store`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all four registers, the bit tracker and `frame_done`. After reset, every view select reads 0x00.
- R2: On a clock edge with `ser_strobe` high, only the register numbered by `ser_addr` (0 to 3) changes. The other three keep their values.
- R3: The addressed register shifts right. Old bit i moves to bit i-1, old bit 0 is dropped, and `ser_bit` enters bit 7. Eight strobed bits sent in the order b0 first, b7 last therefore leave the byte b7..b0, with the first bit sent in bit 0.
- R4: On a clock edge with `ser_strobe` low, no register changes, whatever `ser_bit` and `ser_addr` carry.
- R5: `view_data` shows the register numbered by `view_sel` in the same cycle. No clock edge is needed between a select change and the data.
- R6: `frame_done` is high for exactly one cycle: the cycle after the edge that shifts in the eighth strobed bit to one address. The tracker then starts a new count, so the next pulse needs eight more bits.
- R7: A strobed bit whose address differs from the previous strobed bit restarts the count, and that bit counts as the first bit of a new byte.
- R8: Cycles with `ser_strobe` low pause the count without restarting it. Bits sent to the same address on either side of a gap add up toward the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_bit | input | 1 | Serial data bit |
| ser_addr | input | 2 | Register address for the strobed bit |
| ser_strobe | input | 1 | Shift strobe, enables one shift of the addressed register |
| view_sel | input | 2 | Register shown on `view_data` |
| view_data | output | 8 | Contents of the selected register |
| frame_done | output | 1 | One-cycle pulse when a full byte has been shifted in |

## Verification
The bound checker checks, on every cycle, the per-register rules. These are the shift of the addressed register, holding in every other register and during strobe-low cycles, the same-cycle readout, and the cleared state after reset. It also checks that `frame_done` is never high two cycles in a row and only follows a strobed edge. Exactly where the pulse falls needs the bench's scenarios and its cycle model, because the checker does not see the bit history. That covers the eighth bit at a constant address, a restart on an address change, and the count carried across strobe gaps. The bit order of a complete byte is shown the same way.

// File: rtl/disp_store_pkg.sv
package disp_store_pkg;

   // Implementation choice for the display selector.
   typedef enum logic [0:0] {
      VIEW_INDEXED = 1'b0,
      VIEW_ANDOR   = 1'b1
   } view_mux_e;

   // True when n is a power of two and at least two.
   function automatic bit is_pow2(input int unsigned n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/lane_decoder.sv
module lane_decoder #(
   parameter int unsigned NUM_LANES = 4,
   localparam int unsigned SEL_W    = $clog2(NUM_LANES)
) (
   input  logic                 strobe,
   input  logic [SEL_W-1:0]     addr,
   output logic [NUM_LANES-1:0] lane_en
);

   // One enable per lane, asserted only while the strobe is high.
   for (genvar g = 0; g < NUM_LANES; g++) begin : g_dec
      assign lane_en[g] = strobe && (addr == SEL_W'(g));
   end

endmodule

// File: rtl/shift_lane.sv
module shift_lane #(
   parameter int unsigned LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic              bit_in,
   output logic [LANE_W-1:0] q
);

   logic [LANE_W-1:0] q_r;

   always_ff @(posedge clk) begin
      if (rst) begin
         q_r <= '0;
      end else if (en) begin
         q_r <= {bit_in, q_r[LANE_W-1:1]};
      end
   end

   assign q = q_r;

endmodule

// File: rtl/frame_tracker.sv
module frame_tracker #(
   parameter int unsigned NUM_LANES = 4,
   parameter int unsigned LANE_W    = 8,
   localparam int unsigned SEL_W    = $clog2(NUM_LANES),
   localparam int unsigned CNT_W    = $clog2(LANE_W)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             strobe,
   input  logic [SEL_W-1:0] addr,
   output logic             done
);

   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(LANE_W - 1);

   logic [CNT_W-1:0] cnt_r;
   logic [SEL_W-1:0] last_addr_r;
   logic             done_r;
   logic [CNT_W-1:0] base_cnt;
   logic             byte_full;

   // A strobed bit to a new address starts the byte over.
   always_comb begin
      base_cnt  = (addr == last_addr_r) ? cnt_r : '0;
      byte_full = strobe && (base_cnt == LAST_BIT);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_r       <= '0;
         last_addr_r <= '0;
         done_r      <= 1'b0;
      end else begin
         done_r <= byte_full;
         if (strobe) begin
            last_addr_r <= addr;
            cnt_r       <= byte_full ? '0 : base_cnt + 1'b1;
         end
      end
   end

   assign done = done_r;

endmodule

// File: rtl/view_mux.sv
module view_mux
   import disp_store_pkg::*;
#(
   parameter int unsigned NUM_LANES = 4,
   parameter int unsigned LANE_W    = 8,
   parameter view_mux_e   STYLE     = VIEW_ANDOR,
   localparam int unsigned SEL_W    = $clog2(NUM_LANES)
) (
   input  logic [NUM_LANES*LANE_W-1:0] lanes,
   input  logic [SEL_W-1:0]            sel,
   output logic [LANE_W-1:0]           data
);

   if (STYLE == VIEW_INDEXED) begin : g_indexed
      assign data = lanes[sel*LANE_W +: LANE_W];
   end else begin : g_andor
      logic [NUM_LANES-1:0][LANE_W-1:0] masked;
      for (genvar g = 0; g < NUM_LANES; g++) begin : g_mask
         assign masked[g] = (sel == SEL_W'(g)) ? lanes[g*LANE_W +: LANE_W] : '0;
      end
      always_comb begin
         data = '0;
         for (int i = 0; i < NUM_LANES; i++) begin
            data = data | masked[i];
         end
      end
   end

endmodule

// File: rtl/serial_disp_store.sv
module serial_disp_store
   import disp_store_pkg::*;
#(
   parameter int unsigned NUM_LANES = 4,
   parameter int unsigned LANE_W    = 8,
   parameter view_mux_e   VIEW_MUX  = VIEW_ANDOR,
   localparam int unsigned SEL_W    = $clog2(NUM_LANES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ser_bit,
   input  logic [SEL_W-1:0]  ser_addr,
   input  logic              ser_strobe,
   input  logic [SEL_W-1:0]  view_sel,
   output logic [LANE_W-1:0] view_data,
   output logic              frame_done
);

   // Elaboration-time parameter checks.
   if (!is_pow2(NUM_LANES)) begin : g_bad_lanes
      $error("serial_disp_store: NUM_LANES must be a power of two, at least 2");
   end
   if (LANE_W < 2) begin : g_bad_width
      $error("serial_disp_store: LANE_W must be at least 2");
   end

   logic [NUM_LANES-1:0]        lane_en;
   logic [NUM_LANES*LANE_W-1:0] lane_flat;

   lane_decoder #(
      .NUM_LANES(NUM_LANES)
   ) i_dec (
      .strobe (ser_strobe),
      .addr   (ser_addr),
      .lane_en(lane_en)
   );

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      shift_lane #(
         .LANE_W(LANE_W)
      ) i_lane (
         .clk   (clk),
         .rst   (rst),
         .en    (lane_en[g]),
         .bit_in(ser_bit),
         .q     (lane_flat[g*LANE_W +: LANE_W])
      );
   end

   frame_tracker #(
      .NUM_LANES(NUM_LANES),
      .LANE_W   (LANE_W)
   ) i_track (
      .clk   (clk),
      .rst   (rst),
      .strobe(ser_strobe),
      .addr  (ser_addr),
      .done  (frame_done)
   );

   view_mux #(
      .NUM_LANES(NUM_LANES),
      .LANE_W   (LANE_W),
      .STYLE    (VIEW_MUX)
   ) i_view (
      .lanes(lane_flat),
      .sel  (view_sel),
      .data (view_data)
   );

endmodule

// File: rtl/disp_store_checker.sv
module disp_store_checker #(
   parameter int unsigned NUM_LANES = 4,
   parameter int unsigned LANE_W    = 8,
   localparam int unsigned SEL_W    = $clog2(NUM_LANES)
) (
   input logic                        clk,
   input logic                        rst,
   input logic                        ser_bit,
   input logic [SEL_W-1:0]            ser_addr,
   input logic                        ser_strobe,
   input logic [SEL_W-1:0]            view_sel,
   input logic [LANE_W-1:0]           view_data,
   input logic                        frame_done,
   input logic [NUM_LANES*LANE_W-1:0] lane_flat
);

   logic seen_edge = 1'b0;
   logic rst_q     = 1'b0;

   always_ff @(posedge clk) begin
      seen_edge <= 1'b1;
      rst_q     <= rst;
   end

   // R1: the edge after a reset leaves everything cleared.
   always_ff @(posedge clk) begin
      if (seen_edge && rst_q) begin
         a_r1_reset_clear : assert (lane_flat == '0 && !frame_done)
            else $error("R1: state not cleared after reset");
      end
   end

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane_chk
      // R2 and R3: the addressed lane shifts right with the serial bit on top.
      a_r3_shift_in : assert property (@(posedge clk) disable iff (rst)
         (ser_strobe && ser_addr == SEL_W'(g)) |=>
            lane_flat[g*LANE_W +: LANE_W] ==
            {$past(ser_bit), $past(lane_flat[g*LANE_W+1 +: LANE_W-1])});
      // R2 and R4: lanes that are not addressed keep their value.
      a_r2_others_hold : assert property (@(posedge clk) disable iff (rst)
         (!ser_strobe || ser_addr != SEL_W'(g)) |=>
            $stable(lane_flat[g*LANE_W +: LANE_W]));
   end

   // R4: a low strobe freezes the whole bank.
   a_r4_idle_freeze : assert property (@(posedge clk) disable iff (rst)
      !ser_strobe |=> $stable(lane_flat));

   // R5: the readout follows the select within the cycle.
   a_r5_view_match : assert property (@(posedge clk) disable iff (rst)
      view_data == lane_flat[view_sel*LANE_W +: LANE_W]);

   // R6: the frame pulse lasts a single cycle.
   a_r6_single_pulse : assert property (@(posedge clk) disable iff (rst)
      frame_done |=> !frame_done);

   // R6: the frame pulse always follows a strobed edge.
   a_r6_after_strobe : assert property (@(posedge clk) disable iff (rst)
      frame_done |-> $past(ser_strobe));

endmodule

bind serial_disp_store disp_store_checker #(
   .NUM_LANES(NUM_LANES),
   .LANE_W   (LANE_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .ser_bit   (ser_bit),
   .ser_addr  (ser_addr),
   .ser_strobe(ser_strobe),
   .view_sel  (view_sel),
   .view_data (view_data),
   .frame_done(frame_done),
   .lane_flat (lane_flat)
);

// File: tb/test_serial_disp_store.sv
module test_serial_disp_store;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       ser_bit = 1'b0;
   logic [1:0] ser_addr = 2'd0;
   logic       ser_strobe = 1'b0;
   logic [1:0] view_sel = 2'd0;
   logic [7:0] view_data;
   logic       frame_done;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   // Behavioural reference: bank contents, run length at one address, pulse.
   int mreg [4];
   int run_len;
   int run_addr;
   int mdone;
   bit model_ok = 1'b0;

   always #10 clk = ~clk;

   serial_disp_store i_serial_disp_store (
      .clk       (clk),
      .rst       (rst),
      .ser_bit   (ser_bit),
      .ser_addr  (ser_addr),
      .ser_strobe(ser_strobe),
      .view_sel  (view_sel),
      .view_data (view_data),
      .frame_done(frame_done)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Model of one clock edge with the given inputs.
   task automatic model_edge(input int b, input int a, input int s, input int r);
      if (r != 0) begin
         foreach (mreg[i]) mreg[i] = 0;
         run_len = 0; run_addr = 0; mdone = 0;
         model_ok = 1'b1;
      end else begin
         mdone = 0;
         if (s != 0) begin
            mreg[a] = (mreg[a] >> 1) | (b << 7);
            if (a != run_addr) run_len = 0;
            run_len = run_len + 1;
            run_addr = a;
            if (run_len == 8) begin
               mdone = 1;
               run_len = 0;
            end
         end
      end
   endtask

   // Per-cycle comparison, then drive the next inputs.
   task automatic step(input logic b, input logic [1:0] a, input logic s,
                       input logic [1:0] sel, input logic r);
      @(negedge clk);
      if (model_ok) begin
         chk("R5 view_data", int'(view_data), mreg[view_sel]);
         chk("R6 frame_done", int'(frame_done), mdone);
      end
      ser_bit = b; ser_addr = a; ser_strobe = s; view_sel = sel; rst = r;
      model_edge(int'(b), int'(a), int'(s), int'(r));
   endtask

   // Directed look: check pulse, then show a register with the strobe low.
   task automatic look(input logic [1:0] k, input int exp_view,
                       input int exp_done, input string tag);
      @(negedge clk);
      chk({tag, " frame_done"}, int'(frame_done), exp_done);
      ser_strobe = 1'b0; view_sel = k; rst = 1'b0;
      model_edge(0, 0, 0, 0);
      #2;
      chk({tag, " view"}, int'(view_data), exp_view);
   endtask

   task automatic send_byte(input logic [1:0] a, input logic [7:0] v);
      for (int i = 0; i < 8; i++) step(v[i], a, 1'b1, view_sel, 1'b0);
   endtask

   initial begin
      step(1'b0, 2'd0, 1'b0, 2'd0, 1'b1);
      step(1'b0, 2'd0, 1'b0, 2'd0, 1'b1);
      // R1: every register reads zero after reset.
      for (int k = 0; k < 4; k++) look(2'(k), 0, 0, "R1 reset");

      // R3 and R6: bit order of a full byte and its pulse.
      send_byte(2'd2, 8'hA5);
      look(2'd2, 'hA5, 1, "R3 byte order");
      // R2: other registers untouched.
      look(2'd0, 0, 0, "R2 lane0");
      look(2'd1, 0, 0, "R2 lane1");
      look(2'd3, 0, 0, "R2 lane3");

      // R4: strobe low with changing data and address changes nothing.
      for (int i = 0; i < 6; i++) step(1'b1, 2'(i), 1'b0, 2'd2, 1'b0);
      look(2'd2, 'hA5, 0, "R4 idle hold");

      // R7: three bits to lane 1, then a byte to lane 0.
      for (int i = 0; i < 3; i++) step(1'b1, 2'd1, 1'b1, 2'd1, 1'b0);
      for (int i = 0; i < 5; i++) step(1'(i & 1), 2'd0, 1'b1, 2'd0, 1'b0);
      look(2'd1, 'hE0, 0, "R7 no early pulse");
      for (int i = 5; i < 8; i++) step(1'(i & 1), 2'd0, 1'b1, 2'd0, 1'b0);
      look(2'd0, 'hAA, 1, "R7 restart count");

      // R8: a byte to lane 3 split by idle cycles.
      for (int i = 0; i < 4; i++) step(1'b1, 2'd3, 1'b1, 2'd3, 1'b0);
      for (int i = 0; i < 3; i++) step(1'b0, 2'd1, 1'b0, 2'd3, 1'b0);
      for (int i = 0; i < 4; i++) step(1'b0, 2'd3, 1'b1, 2'd3, 1'b0);
      look(2'd3, 'h0F, 1, "R8 gap keeps count");

      // R6: a second byte back to back to the same lane pulses again.
      send_byte(2'd3, 8'h3C);
      look(2'd3, 'h3C, 1, "R6 second frame");

      // Mixed traffic compared against the model every cycle.
      for (int i = 0; i < 400; i++) begin
         logic [1:0] a;
         a = ($urandom_range(0, 9) == 0) ? 2'($urandom) : ser_addr;
         step(1'($urandom), a, 1'($urandom_range(0, 3) != 0), 2'($urandom), 1'b0);
      end

      // R1: reset in the middle of traffic clears the bank.
      step(1'b0, 2'd0, 1'b0, 2'd0, 1'b1);
      for (int k = 0; k < 4; k++) look(2'(k), 0, 0, "R1 mid reset");

      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule